// File: doc/BRIEF.md
# Base Address Window Decoder

This block decides which address window of a bus target a transaction falls into. It receives the space-enable bits of the target's command register and the raw contents of every base address register, plus an expansion-ROM register in the highest slot. The size of each window, and whether it sits in I/O or memory space, are fixed by parameters. For each window the block derives an aligned base and a last address, then qualifies the window against a strict set of validity rules. A window that fails any rule decodes nothing.

Lookups arrive on a valid/ready request channel carrying an address and a space flag. One cycle after acceptance, the response channel returns a one-hot hit vector and the offset of the address inside the winning window. A response that is not taken stalls the channel: `req_ready` is low while a response waits with `resp_ready` low, and the response holds every bit stable until taken. A request is accepted on any clock edge where both `req_valid` and `req_ready` are high.

Separately from lookups, the block tracks the effective mapping of every window. It emits a one-cycle pulse with a per-window mask whenever a mapping is created, moved or removed, so that downstream routing can tear down and rebuild.

Top module: `bar_window_decoder`

## Requirements
- R1: A window of I/O type decodes only while `cfg_cmd_en[0]` is 1. A memory or ROM window decodes only while `cfg_cmd_en[1]` is 1.
- R2: The effective base of a window is its register value with the low log2(size) bits cleared, and its last address is base + size − 1. An address hits when base ≤ address ≤ last, and the offset reported is address − base.
- R3: A window never decodes when its effective base is zero, when its last address is not above its base, or when its size parameter is zero. A window ending exactly at address 0xFFFFFFFF is valid.
- R4: An I/O request compares only `req_addr[15:0]`, zero-extended. I/O requests hit only I/O windows, and memory requests hit only memory or ROM windows. An I/O window whose last address is 0x10000 or above is disabled.
- R5: The ROM window (highest slot) decodes only while bit 0 of its register is 1. That bit never forms part of the base.
- R6: When windows overlap, the lowest-numbered one wins. `resp_hit` never has more than one bit set.
- R7: When no window matches, `resp_hit` is all zero and `resp_off` is zero.
- R8: Each window has a mapping state: unmapped, or mapped at a base. After reset every window is unmapped. Any change of that state raises `remap_pulse` and the window's `remap_mask` bit on the clock edge after the change, for exactly one cycle if the configuration then stays still. Register changes on a window that stays unmapped raise nothing.
- R9: `req_ready` = !`resp_valid` || `resp_ready`. The response to a request accepted on an edge is valid after that edge. While `resp_valid` is 1 and `resp_ready` is 0, `resp_hit` and `resp_off` hold stable.
- R10: In reset, and on the first cycle after it, `resp_valid` and `remap_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cmd_en | input | 2 | Space enables: bit 0 I/O, bit 1 memory |
| cfg_bar | input | NREG*32 | Window registers, slot i in bits [32i+31:32i]; the highest slot is the ROM |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | 32 | Address to decode |
| req_io | input | 1 | 1 = I/O request, 0 = memory request |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response taken when high |
| resp_hit | output | NREG | One-hot winning window, zero on a miss |
| resp_off | output | 32 | Address minus base of the winning window |
| remap_pulse | output | 1 | A window mapping changed |
| remap_mask | output | NREG | Windows whose mapping changed |

## Verification
The bench builds seven slots: a 256-byte and a 16-byte I/O window, a 4 KiB memory window that can sit inside a 64 KiB one, a 256-byte memory window, an unused zero-size slot and a 2 KiB ROM. The nested memory windows expose the priority order. The 16-byte I/O window can be placed at the very top of the 64 KiB I/O space, or pushed above it, to reach the I/O limit. The small memory window can be dropped to base zero. The zero-size slot shows that an unused slot stays silent even when its register holds a plausible address.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

  localparam int ADDR_W     = 32;
  localparam int IO_EN_BIT  = 0;
  localparam int MEM_EN_BIT = 1;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;
  } win_t;

endpackage

// File: rtl/bar_window_calc.sv
module bar_window_calc
  import bar_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SIZE   = 32'h100,
  parameter bit                IS_IO  = 1'b0,
  parameter bit                IS_ROM = 1'b0,
  parameter int                IO_AW  = 16
) (
  input  logic              io_en,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] bar,
  output win_t              win
);

  localparam logic [ADDR_W-1:0] SPAN   = SIZE - 1'b1;
  localparam logic [ADDR_W-1:0] MASK   = ~SPAN;
  localparam logic [ADDR_W:0]   IO_TOP = (ADDR_W+1)'(1) << IO_AW;
  localparam bit                USED   = (SIZE != '0);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] last;
  logic              space_on;
  logic              fits;

  assign base = bar & MASK;
  assign last = base + SPAN;

  generate
    if (IS_IO) begin : g_io
      assign space_on = io_en;
      assign fits     = ({1'b0, last} < IO_TOP);
    end else if (IS_ROM) begin : g_rom
      assign space_on = mem_en & bar[0];
      assign fits     = 1'b1;
    end else begin : g_mem
      assign space_on = mem_en;
      assign fits     = 1'b1;
    end
  endgenerate

  assign win.en   = USED & space_on & (base != '0) & (last > base) & fits;
  assign win.base = base;
  assign win.last = last;

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
  import bar_dec_pkg::*;
#(
  parameter int               NREG      = 7,
  parameter int               IO_AW     = 16,
  parameter logic [NREG-1:0]  REGION_IO = 7'b0001001
) (
  input  win_t [NREG-1:0]    wins,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_io,
  output logic [NREG-1:0]    hit,
  output logic [ADDR_W-1:0]  off
);

  localparam int PAD_W = ADDR_W - IO_AW;

  logic [ADDR_W-1:0] eff;
  logic [NREG-1:0]   match;

  assign eff = is_io ? {{PAD_W{1'b0}}, addr[IO_AW-1:0]} : addr;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_match
      assign match[i] = wins[i].en && (REGION_IO[i] == is_io) &&
                        (eff >= wins[i].base) && (eff <= wins[i].last);
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    hit   = '0;
    off   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (!found && match[i]) begin
        found  = 1'b1;
        hit[i] = 1'b1;
        off    = eff - wins[i].base;
      end
    end
  end

endmodule

// File: rtl/bar_remap_track.sv
module bar_remap_track
  import bar_dec_pkg::*;
#(
  parameter int NREG = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_t [NREG-1:0]  wins,
  output logic [NREG-1:0]  mask_q
);

  logic [NREG-1:0][ADDR_W:0] key;
  logic [NREG-1:0][ADDR_W:0] key_q;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_key
      assign key[i] = wins[i].en ? {1'b1, wins[i].base} : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      mask_q <= '0;
    end else begin
      key_q <= key;
      for (int i = 0; i < NREG; i++) begin
        mask_q[i] <= (key[i] != key_q[i]);
      end
    end
  end

  // R8
  quiet_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(key) && $past(rst_n)) |=> (mask_q == '0));

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_dec_pkg::*;
#(
  parameter int                     NREG        = 7,
  parameter int                     IO_AW       = 16,
  parameter logic [NREG*ADDR_W-1:0] REGION_SIZE = {32'h800, 32'h0, 32'h100, 32'h10,
                                                   32'h10000, 32'h1000, 32'h100},
  parameter logic [NREG-1:0]        REGION_IO   = 7'b0001001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_cmd_en,
  input  logic [NREG*ADDR_W-1:0] cfg_bar,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_io,
  output logic                   resp_valid,
  input  logic                   resp_ready,
  output logic [NREG-1:0]        resp_hit,
  output logic [ADDR_W-1:0]      resp_off,
  output logic                   remap_pulse,
  output logic [NREG-1:0]        remap_mask
);

  localparam int ROM_SLOT = NREG - 1;
  localparam int ROM_EN_POS = ROM_SLOT * ADDR_W;

  win_t [NREG-1:0]   wins;
  logic [NREG-1:0]   sel_hit;
  logic [ADDR_W-1:0] sel_off;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_win
      bar_window_calc #(
        .SIZE   (REGION_SIZE[i*ADDR_W +: ADDR_W]),
        .IS_IO  (REGION_IO[i]),
        .IS_ROM (i == ROM_SLOT),
        .IO_AW  (IO_AW)
      ) u_calc (
        .io_en  (cfg_cmd_en[IO_EN_BIT]),
        .mem_en (cfg_cmd_en[MEM_EN_BIT]),
        .bar    (cfg_bar[i*ADDR_W +: ADDR_W]),
        .win    (wins[i])
      );
    end
  endgenerate

  bar_hit_select #(
    .NREG      (NREG),
    .IO_AW     (IO_AW),
    .REGION_IO (REGION_IO)
  ) u_sel (
    .wins  (wins),
    .addr  (req_addr),
    .is_io (req_io),
    .hit   (sel_hit),
    .off   (sel_off)
  );

  bar_remap_track #(
    .NREG (NREG)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .wins   (wins),
    .mask_q (remap_mask)
  );

  assign remap_pulse = |remap_mask;
  assign req_ready   = !resp_valid || resp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= '0;
      resp_off   <= '0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit <= sel_hit;
        resp_off <= sel_off;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) && $stable(resp_off)));

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0(resp_hit));

  // R7
  miss_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_hit == '0)) |-> (resp_off == '0));

  // R1
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_io && !cfg_cmd_en[IO_EN_BIT]) |=> (resp_hit == '0));

  // R1
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_io && !cfg_cmd_en[MEM_EN_BIT]) |=> (resp_hit == '0));

  // R5
  rom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_bar[ROM_EN_POS]) |=> !resp_hit[ROM_SLOT]);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!resp_valid && !remap_pulse));

endmodule

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;

  localparam int NREG = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_cmd_en = 2'b11;
  logic [NREG*32-1:0] cfg_bar = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic              req_io = 1'b0;
  logic              resp_valid;
  logic              resp_ready = 1'b1;
  logic [NREG-1:0]   resp_hit;
  logic [31:0]       resp_off;
  logic              remap_pulse;
  logic [NREG-1:0]   remap_mask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bar_window_decoder #(
    .NREG        (NREG),
    .IO_AW       (16),
    .REGION_SIZE ({32'h800, 32'h0, 32'h100, 32'h10, 32'h10000, 32'h1000, 32'h100}),
    .REGION_IO   (7'b0001001)
  ) uut (
    .clk, .rst_n, .cfg_cmd_en, .cfg_bar, .req_valid, .req_ready, .req_addr,
    .req_io, .resp_valid, .resp_ready, .resp_hit, .resp_off, .remap_pulse, .remap_mask
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_bar(int idx, logic [31:0] v);
    @(negedge clk);
    cfg_bar[idx*32 +: 32] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cmd(logic [1:0] v);
    @(negedge clk);
    cfg_cmd_en = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lookup(string tag, logic [31:0] a, logic io,
                        logic [NREG-1:0] eh, logic [31:0] eo);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_io    = io;
    @(negedge clk);
    chk({tag, " valid"}, 64'(resp_valid), 64'd1);
    chk({tag, " hit"}, 64'(resp_hit), 64'(eh));
    chk({tag, " off"}, 64'(resp_off), 64'(eo));
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cfg_bar[0*32 +: 32] = 32'h0000C001;
    cfg_bar[1*32 +: 32] = 32'h80000000;
    cfg_bar[2*32 +: 32] = 32'h80000000;
    cfg_bar[3*32 +: 32] = 32'h0000FFF1;
    cfg_bar[4*32 +: 32] = 32'h90000000;
    cfg_bar[5*32 +: 32] = 32'hB0000000;
    cfg_bar[6*32 +: 32] = 32'hA0000001;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", 64'(resp_valid), 64'd0);
    chk("R10 remap in reset", 64'(remap_pulse), 64'd0);
    chk("R9 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 remap after reset", 64'(remap_pulse), 64'd1);
    chk("R8 mask after reset", 64'(remap_mask), 64'h5F);
    @(negedge clk);
    chk("R8 pulse one cycle", 64'(remap_pulse), 64'd0);
  endtask

  task automatic t_basic;
    lookup("R2 io window", 32'h0000C010, 1'b1, 7'h01, 32'h10);
    lookup("R4 io upper bits ignored", 32'h1234C0FF, 1'b1, 7'h01, 32'hFF);
    lookup("R4 io top of space", 32'h0000FFF5, 1'b1, 7'h08, 32'h5);
    lookup("R6 overlap lowest wins", 32'h80000123, 1'b0, 7'h02, 32'h123);
    lookup("R2 outer window", 32'h80001004, 1'b0, 7'h04, 32'h1004);
    lookup("R4 io request no mem hit", 32'h80000010, 1'b1, 7'h00, 32'h0);
    lookup("R4 mem request no io hit", 32'h0000C010, 1'b0, 7'h00, 32'h0);
  endtask

  task automatic t_rom;
    lookup("R5 rom last byte", 32'hA00007FF, 1'b0, 7'h40, 32'h7FF);
    lookup("R2 rom past end", 32'hA0000800, 1'b0, 7'h00, 32'h0);
    set_bar(6, 32'hA0000000);
    lookup("R5 rom disabled", 32'hA0000010, 1'b0, 7'h00, 32'h0);
    set_bar(6, 32'hA0000001);
  endtask

  task automatic t_cmd;
    set_cmd(2'b01);
    lookup("R1 mem off", 32'h80000010, 1'b0, 7'h00, 32'h0);
    lookup("R1 io still on", 32'h0000C000, 1'b1, 7'h01, 32'h0);
    set_cmd(2'b10);
    lookup("R1 io off", 32'h0000C000, 1'b1, 7'h00, 32'h0);
    lookup("R1 mem on", 32'h90000010, 1'b0, 7'h10, 32'h10);
    set_cmd(2'b11);
  endtask

  task automatic t_invalid;
    set_bar(4, 32'h00000050);
    lookup("R3 base zero", 32'h00000010, 1'b0, 7'h00, 32'h0);
    set_bar(4, 32'h90000000);
    lookup("R3 zero size slot", 32'hB0000000, 1'b0, 7'h00, 32'h0);
    set_bar(1, 32'hFFFFF000);
    lookup("R3 window at top", 32'hFFFFFFFF, 1'b0, 7'h02, 32'hFFF);
    set_bar(1, 32'h80000000);
  endtask

  task automatic t_remap;
    @(negedge clk);
    cfg_bar[4*32 +: 32] = 32'h90000100;
    @(negedge clk);
    chk("R8 move pulse", 64'(remap_pulse), 64'd1);
    chk("R8 move mask", 64'(remap_mask), 64'h10);
    @(negedge clk);
    chk("R8 move pulse ends", 64'(remap_pulse), 64'd0);
    cfg_bar[3*32 +: 32] = 32'h0001FFF1;
    @(negedge clk);
    chk("R8 unmap mask", 64'(remap_mask), 64'h08);
    @(negedge clk);
    cfg_bar[3*32 +: 32] = 32'h0002FFF1;
    @(negedge clk);
    chk("R4 io above limit stays unmapped", 64'(remap_pulse), 64'd0);
    lookup("R4 io limit no hit", 32'h0000FFF5, 1'b1, 7'h00, 32'h0);
    set_bar(3, 32'h0000FFF1);
    lookup("R2 moved window last", 32'h900001FF, 1'b0, 7'h10, 32'hFF);
    lookup("R2 moved window end", 32'h90000200, 1'b0, 7'h00, 32'h0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid  = 1'b1;
    req_addr   = 32'h80000040;
    req_io     = 1'b0;
    @(negedge clk);
    chk("R9 stalled valid", 64'(resp_valid), 64'd1);
    chk("R9 ready low", 64'(req_ready), 64'd0);
    chk("R9 stalled hit", 64'(resp_hit), 64'h02);
    req_addr = 32'h0000C010;
    req_io   = 1'b1;
    cfg_bar[1*32 +: 32] = 32'h70000000;
    @(negedge clk);
    chk("R9 hold hit", 64'(resp_hit), 64'h02);
    chk("R9 hold off", 64'(resp_off), 64'h40);
    resp_ready = 1'b1;
    req_valid  = 1'b0;
    @(negedge clk);
    chk("R9 drained", 64'(resp_valid), 64'd0);
    set_bar(1, 32'h80000000);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_rom();
    t_cmd();
    t_invalid();
    t_remap();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule